// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Program Status Word

This block is the arithmetic and logic engine of a small 8-bit controller core. It holds an accumulator and a program status word (PSW). On each cycle where the execute strobe is high, it combines the accumulator with an 8-bit operand according to a 4-bit opcode. It writes the result back to the accumulator and updates the status flags. The flags are carry, auxiliary (nibble) carry, signed overflow and parity. The flag layout is the conventional one that neighbouring logic decodes by bit position.

Software can also write the PSW as a special-function register at byte address 0xD0. This write sets the carry, auxiliary carry, user flag, bank select and overflow bits. The parity bit always follows the accumulator and cannot be written.

The two bank-select bits drive the bank number output. They also drive the base address of the active group of eight working registers, which the register-file addressing uses directly. Multiply, divide and decimal adjust are handled elsewhere.

Top module: `alu8_core`

## Requirements
- R1: While reset is asserted, and until the first operation after it, the accumulator reads 0x00, the PSW reads 0x00 and the bank outputs read 0.
- R2: Opcode 0 (add) loads A+operand and opcode 1 (add with carry) loads A+operand+CY into the accumulator, modulo 256. CY is PSW bit 7 and is set exactly when the sum exceeds 255.
- R3: For opcodes 0, 1 and 2, the auxiliary carry (PSW bit 6) is set exactly when the low nibbles produce a carry (add) or a borrow (subtract) into bit 4.
- R4: For opcodes 0, 1 and 2, the overflow flag (PSW bit 2) is set exactly when the result read as two's complement falls outside -128..127. This equals the XOR of the carries into and out of bit 7.
- R5: Opcode 2 (subtract with borrow) loads A-operand-CY modulo 256. CY is set exactly when that difference is negative.
- R6: Opcodes 3 (AND), 4 (OR), 5 (XOR), 6 (complement A), 7 (clear A) and 12 (load operand) produce their result in the accumulator. They leave CY, AC and OV unchanged.
- R7: Opcodes 8 (rotate left) and 10 (rotate right) rotate A and touch no flag. Opcodes 9 and 11 rotate left and right through CY and change only CY among the flags.
- R8: PSW bit 0 is 1 exactly when the accumulator holds an odd number of ones. It follows the accumulator at all times, and a PSW write to bit 0 has no effect.
- R9: A write strobe with address 0xD0 stores write-data bits 7:2 into PSW bits 7:2 on the next clock edge. PSW bit 1 always reads 0. A write strobe at any other address changes nothing.
- R10: The bank output equals PSW bits 4:3. The bank base output equals 8 times the bank number.
- R11: With neither the execute strobe nor a PSW write, the accumulator and PSW hold their values. When both occur in one cycle, the PSW takes the written bits, then the operation's flag updates replace the bits it changes. The operation uses the CY held before the edge.
- R12: Opcodes 13, 14 and 15 are no-operations: with the strobe high they change neither the accumulator nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe: perform op_i this cycle |
| op_i | input | 4 | Opcode select |
| opnd_i | input | 8 | Second operand |
| sfr_we_i | input | 1 | Special-function register write strobe |
| sfr_addr_i | input | 8 | Special-function register byte address |
| sfr_wdata_i | input | 8 | Special-function register write data |
| acc_o | output | 8 | Accumulator (operation result) |
| psw_o | output | 8 | Program status word |
| bank_o | output | 2 | Selected working register bank |
| bank_base_o | output | 5 | Base address of the selected bank |

## Verification
Directed corner operands come first. Adding 0x7F+0x01 separates signed overflow from carry out. 0xFF+0x01 gives a carry without overflow. 0x0F+0x01 exposes the nibble carry alone. 0x00-0x01 and 0x80-0x01 do the same for the borrow and subtract-overflow cases. Logic ops and rotates are run with CY, AC and OV preset to both values, which shows whether a non-arithmetic op disturbs them. PSW writes go to 0xD0 and to a neighbouring address, alone and in the same cycle as an operation, which shows the write precedence and address decode. A long seeded random run then mixes all sixteen opcodes with random operands and stray writes, and compares every output against a bench model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned NIB_W  = 4;
    localparam int unsigned OP_W   = 4;

    // Status word bit positions (decoded by neighbouring logic)
    localparam int unsigned PSW_CY  = 7;
    localparam int unsigned PSW_AC  = 6;
    localparam int unsigned PSW_UF  = 5;
    localparam int unsigned PSW_RSH = 4;
    localparam int unsigned PSW_RSL = 3;
    localparam int unsigned PSW_OV  = 2;
    localparam int unsigned PSW_P   = 0;

    // Bits 7:2 are storable; bits 1:0 are never held
    localparam logic [DATA_W-1:0] PSW_STORE_MASK = 8'hFC;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_CPL  = 4'd6,
        OP_CLR  = 4'd7,
        OP_RL   = 4'd8,
        OP_RLC  = 4'd9,
        OP_RR   = 4'd10,
        OP_RRC  = 4'd11,
        OP_LOAD = 4'd12,
        OP_NOPA = 4'd13,
        OP_NOPB = 4'd14,
        OP_NOPC = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] psw;
    } core_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              ac;
        logic              ov;
    } arith_out_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              cy_we;
    } logic_out_t;

    function automatic logic is_arith(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction

    function automatic logic is_logic(input logic [OP_W-1:0] op);
        return (op >= OP_AND) && (op <= OP_RRC);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int unsigned W   = DATA_W,
    parameter int unsigned NIB = NIB_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         ac_o,
    output logic         ov_o
);

    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [NIB:0]   lo_sum;
    logic [W-1:0]   low7_sum;
    logic [W:0]     full_sum;
    logic           c_out;
    logic           c_into_msb;

    // Subtraction is done as a + ~b + ~borrow; carries are inverted back.
    always_comb begin
        b_eff      = sub_i ? ~b_i : b_i;
        c_eff      = sub_i ? ~cin_i : cin_i;
        lo_sum     = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]}
                   + {{NIB{1'b0}}, c_eff};
        low7_sum   = {1'b0, a_i[W-2:0]} + {1'b0, b_eff[W-2:0]}
                   + {{(W-1){1'b0}}, c_eff};
        full_sum   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        c_out      = full_sum[W];
        c_into_msb = low7_sum[W-1];
        res_o      = full_sum[W-1:0];
        cy_o       = sub_i ? ~c_out : c_out;
        ac_o       = sub_i ? ~lo_sum[NIB] : lo_sum[NIB];
        ov_o       = c_out ^ c_into_msb;
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            cin_i,
    input  logic [OP_W-1:0] op_i,
    output logic [W-1:0]    res_o,
    output logic            cy_o,
    output logic            cy_we_o
);

    always_comb begin
        res_o   = a_i;
        cy_o    = cin_i;
        cy_we_o = 1'b0;
        case (op_i)
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_CPL: res_o = ~a_i;
            OP_CLR: res_o = '0;
            OP_RL:  res_o = {a_i[W-2:0], a_i[W-1]};
            OP_RR:  res_o = {a_i[0], a_i[W-1:1]};
            OP_RLC: begin
                res_o   = {a_i[W-2:0], cin_i};
                cy_o    = a_i[W-1];
                cy_we_o = 1'b1;
            end
            OP_RRC: begin
                res_o   = {cin_i, a_i[W-1:1]};
                cy_o    = a_i[0];
                cy_we_o = 1'b1;
            end
            default: res_o = a_i;
        endcase
    end

endmodule

// File: rtl/alu8_parity.sv
module alu8_parity #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] d_i,
    output logic         odd_o
);

    logic [W-1:0] chain;

    assign chain[0] = d_i[0];

    for (genvar gi = 1; gi < W; gi++) begin : g_chain
        assign chain[gi] = chain[gi-1] ^ d_i[gi];
    end

    assign odd_o = chain[W-1];

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter logic [7:0]  PSW_ADDR  = 8'hD0,
    parameter int unsigned BANK_REGS = 8,
    localparam int unsigned SHIFT_W  = $clog2(BANK_REGS),
    localparam int unsigned BASE_W   = SHIFT_W + 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exec_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic              sfr_we_i,
    input  logic [7:0]        sfr_addr_i,
    input  logic [DATA_W-1:0] sfr_wdata_i,
    output logic [DATA_W-1:0] acc_o,
    output logic [DATA_W-1:0] psw_o,
    output logic [1:0]        bank_o,
    output logic [BASE_W-1:0] bank_base_o
);

    core_state_t state_d, state_q;
    arith_out_t  ar;
    logic_out_t  lg;
    logic        psw_wr;
    logic        arith_cin;
    logic        parity_odd;

    assign psw_wr    = sfr_we_i && (sfr_addr_i == PSW_ADDR);
    assign arith_cin = (op_i == OP_ADD) ? 1'b0 : state_q.psw[PSW_CY];

    alu8_arith #(.W(DATA_W), .NIB(NIB_W)) i_arith (
        .a_i   (state_q.acc),
        .b_i   (opnd_i),
        .cin_i (arith_cin),
        .sub_i (op_i == OP_SUBB),
        .res_o (ar.res),
        .cy_o  (ar.cy),
        .ac_o  (ar.ac),
        .ov_o  (ar.ov)
    );

    alu8_logic #(.W(DATA_W)) i_logic (
        .a_i     (state_q.acc),
        .b_i     (opnd_i),
        .cin_i   (state_q.psw[PSW_CY]),
        .op_i    (op_i),
        .res_o   (lg.res),
        .cy_o    (lg.cy),
        .cy_we_o (lg.cy_we)
    );

    alu8_parity #(.W(DATA_W)) i_parity (
        .d_i   (state_q.acc),
        .odd_o (parity_odd)
    );

    // Next-state: software write first, operation flag updates on top.
    always_comb begin
        state_d = state_q;
        if (psw_wr) begin
            state_d.psw = sfr_wdata_i & PSW_STORE_MASK;
        end
        if (exec_i) begin
            if (is_arith(op_i)) begin
                state_d.acc         = ar.res;
                state_d.psw[PSW_CY] = ar.cy;
                state_d.psw[PSW_AC] = ar.ac;
                state_d.psw[PSW_OV] = ar.ov;
            end else if (is_logic(op_i)) begin
                state_d.acc = lg.res;
                if (lg.cy_we) begin
                    state_d.psw[PSW_CY] = lg.cy;
                end
            end else if (op_i == OP_LOAD) begin
                state_d.acc = opnd_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_o       = state_q.acc;
    assign psw_o       = (state_q.psw & PSW_STORE_MASK)
                       | {{(DATA_W-1){1'b0}}, parity_odd};
    assign bank_o      = state_q.psw[PSW_RSH:PSW_RSL];
    assign bank_base_o = {bank_o, {SHIFT_W{1'b0}}};

    // R11: nothing requested -> everything holds
    p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!exec_i && !sfr_we_i) |=> ($stable(acc_o) && $stable(psw_o)));

    // R6: non-rotating logic ops keep CY, AC, OV
    p_logic_keeps_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && !psw_wr && (op_i >= OP_AND) && (op_i <= OP_CLR))
        |=> ($stable(psw_o[7:6]) && $stable(psw_o[2])));

    // R7: rotate left through carry moves old bit 7 into CY
    p_rlc_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && (op_i == OP_RLC)) |=> (psw_o[7] == $past(acc_o[7])));

    // R8: clear leaves an even accumulator
    p_clr_parity_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && (op_i == OP_CLR)) |=> (acc_o == '0 && psw_o[0] == 1'b0));

    // R10: a status write selects the written bank
    p_bank_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        psw_wr |=> (bank_o == $past(sfr_wdata_i[4:3])));

    // R12: no-operation codes change nothing
    p_nop_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exec_i && !sfr_we_i && (op_i >= OP_NOPA)) |=> ($stable(acc_o) && $stable(psw_o)));

endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec = 1'b0;
    logic [3:0] op = 4'd0;
    logic [7:0] opnd = 8'd0;
    logic       we = 1'b0;
    logic [7:0] addr = 8'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] acc_o, psw_o;
    logic [1:0] bank_o;
    logic [4:0] base_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_acc = 8'd0;
    logic [7:0] m_psw = 8'd0; // stored bits 7:2 only

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .op_i(op), .opnd_i(opnd),
        .sfr_we_i(we), .sfr_addr_i(addr), .sfr_wdata_i(wdata),
        .acc_o(acc_o), .psw_o(psw_o), .bank_o(bank_o), .bank_base_o(base_o)
    );

    function automatic string tag_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R2";
            4'd2: return "R5";
            4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd12: return "R6";
            4'd8, 4'd9, 4'd10, 4'd11: return "R7";
            default: return "R12";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] ep;
        ep = {m_psw[7:2], 1'b0, ^m_acc};
        check8(acc_o, m_acc, tag, "acc");
        check8(psw_o, ep, tag, "psw");
        check8({6'd0, bank_o}, {6'd0, m_psw[4:3]}, tag, "bank");
        check8({3'd0, base_o}, {1'b0, m_psw[4:3], 3'd0}, tag, "base");
    endtask

    task automatic model(input logic ex, input logic [3:0] o, input logic [7:0] b,
                         input logic w, input logic [7:0] ad, input logic [7:0] wd);
        logic [7:0] np, na;
        int a, bi, ci, r, lo, sr;
        logic cy;
        np = m_psw; na = m_acc; cy = m_psw[7];
        a = int'(m_acc); bi = int'(b);
        if (w && ad == 8'hD0) np = wd & 8'hFC;
        if (ex) begin
            case (o)
                4'd0, 4'd1, 4'd2: begin
                    ci = (o == 4'd0) ? 0 : int'(cy);
                    if (o == 4'd2) begin
                        r = a - bi - ci; lo = (a & 15) - (bi & 15) - ci;
                        sr = sgn(a) - sgn(bi) - ci;
                        np[7] = (r < 0); np[6] = (lo < 0);
                    end else begin
                        r = a + bi + ci; lo = (a & 15) + (bi & 15) + ci;
                        sr = sgn(a) + sgn(bi) + ci;
                        np[7] = (r > 255); np[6] = (lo > 15);
                    end
                    np[2] = (sr > 127) || (sr < -128);
                    na = r[7:0];
                end
                4'd3: na = m_acc & b;
                4'd4: na = m_acc | b;
                4'd5: na = m_acc ^ b;
                4'd6: na = ~m_acc;
                4'd7: na = 8'd0;
                4'd8: na = {m_acc[6:0], m_acc[7]};
                4'd9: begin na = {m_acc[6:0], cy}; np[7] = m_acc[7]; end
                4'd10: na = {m_acc[0], m_acc[7:1]};
                4'd11: begin na = {cy, m_acc[7:1]}; np[7] = m_acc[0]; end
                4'd12: na = b;
                default: ;
            endcase
        end
        m_acc = na; m_psw = np;
    endtask

    task automatic step(input logic ex, input logic [3:0] o, input logic [7:0] b,
                        input logic w, input logic [7:0] ad, input logic [7:0] wd,
                        input string tag);
        exec = ex; op = o; opnd = b; we = w; addr = ad; wdata = wd;
        model(ex, o, b, w, ad, wd);
        @(negedge clk);
        exec = 1'b0; we = 1'b0;
        check_all(tag);
    endtask

    task automatic do_op(input logic [3:0] o, input logic [7:0] b, input string tag);
        step(1'b1, o, b, 1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic wr_psw(input logic [7:0] wd, input string tag);
        step(1'b0, 4'd0, 8'h00, 1'b1, 8'hD0, wd, tag);
    endtask

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h5EED_0051);
        @(negedge clk);
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 / R3 / R4 add corners
        do_op(4'd12, 8'h7F, "R6");
        do_op(4'd0, 8'h01, "R4");   // 0x80, OV=1, AC=1, CY=0
        do_op(4'd12, 8'hFF, "R6");
        do_op(4'd0, 8'h01, "R2");   // 0x00, CY=1, OV=0
        do_op(4'd12, 8'h0F, "R6");
        do_op(4'd1, 8'h00, "R3");   // ADDC with CY=1: nibble carry only
        do_op(4'd0, 8'h80, "R4");   // 0x10+0x80 no overflow
        do_op(4'd12, 8'h80, "R6");
        do_op(4'd0, 8'h80, "R4");   // 0x80+0x80: CY=1, OV=1
        // R5 subtract corners
        wr_psw(8'h00, "R9");
        do_op(4'd12, 8'h00, "R6");
        do_op(4'd2, 8'h01, "R5");   // 0xFF, CY=1, AC=1
        do_op(4'd2, 8'h00, "R5");   // with borrow in
        do_op(4'd12, 8'h80, "R6");
        wr_psw(8'h00, "R9");
        do_op(4'd2, 8'h01, "R4");   // 0x7F, OV=1
        // R6 logic with all flags preset 1, then 0
        wr_psw(8'hC4, "R9");
        do_op(4'd3, 8'h3C, "R6");
        do_op(4'd6, 8'h00, "R6");
        do_op(4'd7, 8'h00, "R6");
        wr_psw(8'h00, "R9");
        do_op(4'd4, 8'hA5, "R6");
        do_op(4'd5, 8'hFF, "R6");
        // R7 rotates
        do_op(4'd12, 8'h81, "R6");
        do_op(4'd8, 8'h00, "R7");
        do_op(4'd9, 8'h00, "R7");
        do_op(4'd11, 8'h00, "R7");
        do_op(4'd10, 8'h00, "R7");
        // R8 / R9 / R10 status writes
        wr_psw(8'hFF, "R8");
        wr_psw(8'h10, "R10");
        wr_psw(8'h08, "R10");
        step(1'b0, 4'd0, 8'h00, 1'b1, 8'hD1, 8'hFF, "R9");
        step(1'b0, 4'd0, 8'h00, 1'b1, 8'h50, 8'h18, "R9");
        // R11 hold and same-cycle precedence
        step(1'b0, 4'd0, 8'h55, 1'b0, 8'hD0, 8'hFF, "R11");
        do_op(4'd12, 8'hF0, "R6");
        step(1'b1, 4'd0, 8'h20, 1'b1, 8'hD0, 8'h38, "R11");
        step(1'b1, 4'd1, 8'h01, 1'b1, 8'hD0, 8'h00, "R11");
        // R12 no-operations
        do_op(4'd13, 8'hFF, "R12");
        do_op(4'd14, 8'h00, "R12");
        do_op(4'd15, 8'h5A, "R12");

        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ro;
            logic rw;
            ro = 4'($urandom_range(0, 15));
            rw = ($urandom_range(0, 7) == 0);
            step(($urandom_range(0, 9) != 0), ro, 8'($urandom),
                 rw, ($urandom_range(0, 1) == 0) ? 8'hD0 : 8'($urandom),
                 8'($urandom), tag_of(ro));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule